// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Front-End

This block is the target side of a small serial NOR memory model. A host selects it with an active-low select line, clocks it through a serial clock, and exchanges bits over four IO lines that each have their own output enable. The host first sends an eight-bit instruction on IO0. Depending on the opcode, the block then takes a 24-bit address, counts out a number of dummy clocks, and returns bytes from an internal byte array over one, two or four lines. Reads continue until select is released, and the address increments after each byte.

The block samples the serial clock, select and IO lines with the system clock through a short synchronizer. It acts on clock edges it detects in those samples, so it needs no clock of its own. Instructions that use four lines are honoured only while a quad-enable bit in the second status register is set. A small write port sets or clears that bit for test purposes. After a reset the block stays deaf until it has seen select high, so a select held low across reset cannot start a transfer.

Top module: `flash_mio_front`

## Requirements
- R1: Both idle clock levels are supported (low = mode 0, high = mode 3). Input bits are taken on rising serial-clock edges. Driven output bits change only after falling edges.
- R2: The instruction is eight bits, MSB first, on IO0. An opcode other than 0x0B, 0x3B, 0xBB, 0x6B, 0xEB, 0x05 or 0x35 leaves all IO lines released until select goes high.
- R3: Opcode 0x0B takes a 24-bit address MSB first on IO0, then 8 dummy clocks, then returns data MSB first on IO1 only.
- R4: Opcode 0x3B takes the address on IO0, then 8 dummy clocks, then returns two bits per clock: IO1 carries the higher bit and IO0 the lower.
- R5: Opcode 0xBB takes the address two bits per clock (IO1 higher), then 4 dummy clocks, then returns data as in R4.
- R6: Opcode 0x6B takes the address on IO0 with 8 dummy clocks, and opcode 0xEB takes it four bits per clock (IO3 highest) with 4 dummy clocks. Both return four bits per clock, with IO3 carrying the highest bit of each nibble, high nibble first.
- R7: While the quad-enable bit is clear, 0x6B and 0xEB are refused and no output enable rises until select goes high.
- R8: Successive bytes come from successive addresses, and the index wraps from the top of the array to 0. Byte i of the array holds (29*i + 0x5A) mod 256 after reset.
- R9: Select going high at any point releases every IO line within a few system clocks. The next select starts a fresh instruction.
- R10: After reset, no transfer starts until select has been observed high. A select held low through reset is ignored.
- R11: During and right after reset, all output enables are 0.
- R12: Opcode 0x05 returns status byte 0x00 and opcode 0x35 returns status byte {6'b0, qe, 1'b0}. Both go out on IO1 with no address or dummy clocks and repeat until select rises. qe_we_i loads qe_d_i into the quad-enable bit.
- R13: During the data phase the output enables are 4'b0010 for one lane, 4'b0011 for two lanes and 4'b1111 for four lanes. At all other times they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low select |
| io_i | input | 4 | Sampled levels of IO3..IO0 |
| io_o | output | 4 | Values driven onto IO3..IO0 |
| io_oe_o | output | 4 | Per-line output enables |
| qe_we_i | input | 1 | Write strobe for the quad-enable bit |
| qe_d_i | input | 1 | New quad-enable value |

## Verification
Every read opcode is run at least once, so that the lane count in the address, the dummy count and the lane count in the data each show up as wrong bytes if any one of them is off. A single-lane read is repeated with the clock idling high to separate edge handling from mode. Quad reads run with the enable clear and then set, and status reads run before and after the enable changes. A read across the top of the array checks the wrap. Further runs cover an unknown opcode, a select held low through reset, and an abort part-way through a byte, checking that the lines are released and that the next transfer is unaffected.

// File: rtl/flash_mio_pkg.sv
package flash_mio_pkg;

  typedef enum logic [1:0] {LN1 = 2'd0, LN2 = 2'd1, LN4 = 2'd2} lane_e;

  typedef enum logic [2:0] {
    ST_CMD   = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DUMMY = 3'd2,
    ST_XMIT  = 3'd3,
    ST_HALT  = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic       valid;
    logic       need_qe;
    logic       is_stat;
    logic       stat_hi;
    lane_e      addr_ln;
    lane_e      data_ln;
    logic [3:0] dummy;
  } op_cfg_t;

  localparam logic [7:0] OPC_RD_FAST = 8'h0B;
  localparam logic [7:0] OPC_RD_DO   = 8'h3B;
  localparam logic [7:0] OPC_RD_DIO  = 8'hBB;
  localparam logic [7:0] OPC_RD_QO   = 8'h6B;
  localparam logic [7:0] OPC_RD_QIO  = 8'hEB;
  localparam logic [7:0] OPC_SR_LO   = 8'h05;
  localparam logic [7:0] OPC_SR_HI   = 8'h35;

  function automatic op_cfg_t op_decode(input logic [7:0] op,
                                        input logic [3:0] dly_out,
                                        input logic [3:0] dly_io);
    op_cfg_t c;
    c = '0;
    c.addr_ln = LN1;
    c.data_ln = LN1;
    case (op)
      OPC_RD_FAST: begin c.valid = 1'b1; c.dummy = dly_out; end
      OPC_RD_DO: begin
        c.valid = 1'b1; c.data_ln = LN2; c.dummy = dly_out;
      end
      OPC_RD_DIO: begin
        c.valid = 1'b1; c.addr_ln = LN2; c.data_ln = LN2; c.dummy = dly_io;
      end
      OPC_RD_QO: begin
        c.valid = 1'b1; c.need_qe = 1'b1; c.data_ln = LN4; c.dummy = dly_out;
      end
      OPC_RD_QIO: begin
        c.valid = 1'b1; c.need_qe = 1'b1; c.addr_ln = LN4; c.data_ln = LN4;
        c.dummy = dly_io;
      end
      OPC_SR_LO: begin c.valid = 1'b1; c.is_stat = 1'b1; end
      OPC_SR_HI: begin c.valid = 1'b1; c.is_stat = 1'b1; c.stat_hi = 1'b1; end
      default: c.valid = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/flash_mio_sync.sv
module flash_mio_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic [3:0] io_i,
  output logic       sclk_rise_o,
  output logic       sclk_fall_o,
  output logic       cs_high_o,
  output logic [3:0] io_s_o,
  output logic       armed_o
);
  localparam int W = 6;

  logic [STAGES-1:0][W-1:0] chain_q;
  logic                     sclk_prev_q;
  logic                     armed_q;
  logic                     sclk_s;

  // lines are assumed low at reset, so a select that stays low never arms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q     <= '0;
      sclk_prev_q <= 1'b0;
      armed_q     <= 1'b0;
    end else begin
      chain_q     <= {chain_q[STAGES-2:0], {io_i, cs_ni, sclk_i}};
      sclk_prev_q <= sclk_s;
      if (cs_high_o) armed_q <= 1'b1;
    end
  end

  assign sclk_s      = chain_q[STAGES-1][0];
  assign cs_high_o   = chain_q[STAGES-1][1];
  assign io_s_o      = chain_q[STAGES-1][5:2];
  assign sclk_rise_o = sclk_s & ~sclk_prev_q;
  assign sclk_fall_o = ~sclk_s & sclk_prev_q;
  assign armed_o     = armed_q;

endmodule

// File: rtl/flash_mio_store.sv
module flash_mio_store #(
  parameter int BYTES = 256,
  parameter int MUL   = 29,
  parameter int ADD   = 90,
  localparam int AW   = $clog2(BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] cell_q [BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BYTES; i++) cell_q[i] <= 8'(i * MUL + ADD);
    end
  end

  assign rd_data_o = cell_q[rd_addr_i];

endmodule

// File: rtl/flash_mio_seq.sv
module flash_mio_seq
  import flash_mio_pkg::*;
#(
  parameter int ADDR_BITS = 24,
  parameter int MEM_AW    = 8,
  parameter int DUMMY_OUT = 8,
  parameter int DUMMY_IO  = 4,
  localparam int CW       = $clog2(ADDR_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [3:0]        io_s_i,
  input  logic              qe_i,
  input  logic [7:0]        sr1_i,
  input  logic [7:0]        sr2_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o
);
  localparam logic [3:0] DLY_OUT = 4'(DUMMY_OUT);
  localparam logic [3:0] DLY_IO  = 4'(DUMMY_IO);

  seq_st_e              st_q;
  op_cfg_t              cfg_q, dec;
  logic [CW-1:0]        cnt_q, addr_last;
  logic [7:0]           cmd_q, dsh_q, dsh_shift, stat_q;
  logic [ADDR_BITS-1:0] addr_q, addr_shift;
  logic [2:0]           dcnt_q, chunk_last;
  logic [3:0]           io_q, oe_q, out_bits, lane_mask;

  always_comb begin
    dec = op_decode({cmd_q[6:0], io_s_i[0]}, DLY_OUT, DLY_IO);
    case (cfg_q.addr_ln)
      LN2: begin
        addr_shift = {addr_q[ADDR_BITS-3:0], io_s_i[1:0]};
        addr_last  = CW'(ADDR_BITS / 2 - 1);
      end
      LN4: begin
        addr_shift = {addr_q[ADDR_BITS-5:0], io_s_i[3:0]};
        addr_last  = CW'(ADDR_BITS / 4 - 1);
      end
      default: begin
        addr_shift = {addr_q[ADDR_BITS-2:0], io_s_i[0]};
        addr_last  = CW'(ADDR_BITS - 1);
      end
    endcase
    case (cfg_q.data_ln)
      LN2: begin
        out_bits = {2'b00, dsh_q[7:6]}; lane_mask = 4'b0011;
        chunk_last = 3'd3; dsh_shift = {dsh_q[5:0], 2'b00};
      end
      LN4: begin
        out_bits = dsh_q[7:4]; lane_mask = 4'b1111;
        chunk_last = 3'd1; dsh_shift = {dsh_q[3:0], 4'b0000};
      end
      default: begin
        out_bits = {2'b00, dsh_q[7], 1'b0}; lane_mask = 4'b0010;
        chunk_last = 3'd7; dsh_shift = {dsh_q[6:0], 1'b0};
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CMD;
      cfg_q  <= '0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      dsh_q  <= '0;
      stat_q <= '0;
      addr_q <= '0;
      dcnt_q <= '0;
      io_q   <= '0;
      oe_q   <= '0;
    end else if (!sel_i) begin
      st_q  <= ST_CMD;
      cnt_q <= '0;
      io_q  <= '0;
      oe_q  <= '0;
    end else begin
      if (rise_i) begin
        case (st_q)
          ST_CMD: begin
            cmd_q <= {cmd_q[6:0], io_s_i[0]};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(7)) begin
              cfg_q <= dec;
              cnt_q <= '0;
              if (!dec.valid || (dec.need_qe && !qe_i)) begin
                st_q <= ST_HALT;
              end else if (dec.is_stat) begin
                st_q   <= ST_XMIT;
                stat_q <= dec.stat_hi ? sr2_i : sr1_i;
                dsh_q  <= dec.stat_hi ? sr2_i : sr1_i;
                dcnt_q <= '0;
              end else begin
                st_q <= ST_ADDR;
              end
            end
          end
          ST_ADDR: begin
            addr_q <= addr_shift;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == addr_last) begin
              cnt_q <= '0;
              st_q  <= ST_DUMMY;
            end
          end
          ST_DUMMY: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(cfg_q.dummy) - CW'(1)) begin
              st_q   <= ST_XMIT;
              dsh_q  <= mem_data_i;
              addr_q <= addr_q + 1'b1;
              dcnt_q <= '0;
            end
          end
          default: ;
        endcase
      end
      // data leaves on the falling edge so it is settled at the next rise
      if (fall_i && st_q == ST_XMIT) begin
        oe_q <= lane_mask;
        io_q <= out_bits;
        if (dcnt_q == chunk_last) begin
          dcnt_q <= '0;
          if (cfg_q.is_stat) begin
            dsh_q <= stat_q;
          end else begin
            dsh_q  <= mem_data_i;
            addr_q <= addr_q + 1'b1;
          end
        end else begin
          dsh_q  <= dsh_shift;
          dcnt_q <= dcnt_q + 1'b1;
        end
      end
    end
  end

  assign mem_addr_o = addr_q[MEM_AW-1:0];
  assign io_o       = io_q;
  assign io_oe_o    = oe_q;

endmodule

// File: rtl/flash_mio_front.sv
module flash_mio_front #(
  parameter int MEM_BYTES   = 256,
  parameter int ADDR_BITS   = 24,
  parameter int DUMMY_OUT   = 8,
  parameter int DUMMY_IO    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic [3:0] io_i,
  output logic [3:0] io_o,
  output logic [3:0] io_oe_o,
  input  logic       qe_we_i,
  input  logic       qe_d_i
);
  localparam int MEM_AW = $clog2(MEM_BYTES);

  logic              sclk_rise, sclk_fall, cs_s, armed, qe_q;
  logic [3:0]        io_s;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0]        mem_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      qe_q <= 1'b0;
    else if (qe_we_i) qe_q <= qe_d_i;
  end

  flash_mio_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .cs_ni      (cs_ni),
    .io_i       (io_i),
    .sclk_rise_o(sclk_rise),
    .sclk_fall_o(sclk_fall),
    .cs_high_o  (cs_s),
    .io_s_o     (io_s),
    .armed_o    (armed)
  );

  flash_mio_store #(.BYTES(MEM_BYTES)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_addr_i(mem_addr),
    .rd_data_o(mem_data)
  );

  flash_mio_seq #(
    .ADDR_BITS(ADDR_BITS),
    .MEM_AW   (MEM_AW),
    .DUMMY_OUT(DUMMY_OUT),
    .DUMMY_IO (DUMMY_IO)
  ) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (armed & ~cs_s),
    .rise_i    (sclk_rise),
    .fall_i    (sclk_fall),
    .io_s_i    (io_s),
    .qe_i      (qe_q),
    .sr1_i     (8'h00),
    .sr2_i     ({6'b0, qe_q, 1'b0}),
    .mem_addr_o(mem_addr),
    .mem_data_i(mem_data),
    .io_o      (io_o),
    .io_oe_o   (io_oe_o)
  );

endmodule

// File: rtl/flash_mio_chk.sv
module flash_mio_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_high_i,
  input logic       armed_i,
  input logic       sclk_fall_i,
  input logic       qe_i,
  input logic [3:0] io_i,
  input logic [3:0] oe_i
);
  // R11
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_release_chk: assert (oe_i == 4'b0000);
    end
  end

  // R13
  oe_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i == 4'b0000) || (oe_i == 4'b0010) || (oe_i == 4'b0011) || (oe_i == 4'b1111));

  // R7
  quad_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i == 4'b1111 && $past(oe_i) != 4'b1111) |-> qe_i);

  // R9
  deselect_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_high_i |=> (oe_i == 4'b0000));

  // R10
  unarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> (oe_i == 4'b0000));

  // R1
  fall_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i != 4'b0000 && $past(oe_i) != 4'b0000 && io_i != $past(io_i))
      |-> $past(sclk_fall_i));

endmodule

bind flash_mio_front flash_mio_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_high_i  (cs_s),
  .armed_i    (armed),
  .sclk_fall_i(sclk_fall),
  .qe_i       (qe_q),
  .io_i       (io_o),
  .oe_i       (io_oe_o)
);

// File: tb/test_flash_mio_front.sv
module test_flash_mio_front;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b0;
  logic [3:0] io_in = 4'b0;
  logic [3:0] io_out, io_oe;
  logic       qe_we = 1'b0;
  logic       qe_d = 1'b0;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  flash_mio_front i_flash_mio_front (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sclk_i (sclk),
    .cs_ni  (cs_n),
    .io_i   (io_in),
    .io_o   (io_out),
    .io_oe_o(io_oe),
    .qe_we_i(qe_we),
    .qe_d_i (qe_d)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(((i % 256) * 29 + 90) % 256);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic spi_cycle(input logic [3:0] drv, output logic [3:0] s_io,
                           output logic [3:0] s_oe);
    sclk  = 1'b0;
    io_in = drv;
    wait_clk(H);
    s_io = io_out;
    s_oe = io_oe;
    sclk = 1'b1;
    wait_clk(H);
  endtask

  task automatic send_header(input logic [7:0] op, input logic [23:0] adr,
                             input int al, input int dc);
    logic [3:0] s_io, s_oe, d;
    for (int i = 7; i >= 0; i--) spi_cycle({3'b000, op[i]}, s_io, s_oe);
    if (al > 0) begin
      for (int k = 0; k < 24 / al; k++) begin
        d = 4'((adr >> (24 - al * (k + 1))) & ((1 << al) - 1));
        spi_cycle(d, s_io, s_oe);
      end
    end
    for (int k = 0; k < dc; k++) spi_cycle(4'b0, s_io, s_oe);
  endtask

  task automatic xfer(input logic [7:0] op, input logic [23:0] adr, input int al,
                      input int dc, input int dl, input int nb, input bit m3,
                      input bit drive, input bit is_const, input logic [7:0] cval,
                      input string req);
    logic [3:0] s_io, s_oe, mask;
    logic [7:0] byte_v;
    bit         stray;
    mask  = (dl == 1) ? 4'b0010 : (dl == 2) ? 4'b0011 : 4'b1111;
    stray = 1'b0;
    sclk  = m3;
    cs_n  = 1'b1;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(4);
    send_header(op, adr, al, dc);
    for (int b = 0; b < nb; b++) begin
      byte_v = 8'h00;
      for (int c = 0; c < 8 / dl; c++) begin
        spi_cycle(4'b0, s_io, s_oe);
        if (s_oe != 4'b0000) stray = 1'b1;
        case (dl)
          1:       byte_v = {byte_v[6:0], s_io[1]};
          2:       byte_v = {byte_v[5:0], s_io[1:0]};
          default: byte_v = {byte_v[3:0], s_io};
        endcase
      end
      if (drive) begin
        check("R13", "lane enables", 32'(s_oe), 32'(mask));
        check(req, "data byte", 32'(byte_v),
              32'(is_const ? cval : pat(int'(adr[7:0]) + b)));
      end
    end
    if (!drive) check(req, "lines released", 32'(stray), 32'd0);
    if (!m3) sclk = 1'b0;
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(8);
    check("R9", "released after select high", 32'(io_oe), 32'd0);
  endtask

  task automatic t_reset_cs_low();
    logic [3:0] s_io, s_oe;
    bit stray;
    stray = 1'b0;
    cs_n  = 1'b0;
    sclk  = 1'b0;
    wait_clk(5);
    check("R11", "enables in reset", 32'(io_oe), 32'd0);
    rst_n = 1'b1;
    wait_clk(4);
    check("R11", "enables after reset", 32'(io_oe), 32'd0);
    send_header(8'h0B, 24'h000010, 1, 8);
    for (int c = 0; c < 16; c++) begin
      spi_cycle(4'b0, s_io, s_oe);
      if (s_oe != 4'b0000) stray = 1'b1;
    end
    check("R10", "low select through reset ignored", 32'(stray), 32'd0);
    sclk = 1'b0;
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic t_single();
    xfer(8'h0B, 24'h000010, 1, 8, 1, 3, 1'b0, 1'b1, 1'b0, 8'h00, "R3");
    xfer(8'h0B, 24'h123480, 1, 8, 1, 2, 1'b1, 1'b1, 1'b0, 8'h00, "R1");
  endtask

  task automatic t_dual();
    xfer(8'h3B, 24'h000020, 1, 8, 2, 4, 1'b0, 1'b1, 1'b0, 8'h00, "R4");
    xfer(8'hBB, 24'hA5A537, 2, 4, 2, 3, 1'b0, 1'b1, 1'b0, 8'h00, "R5");
  endtask

  task automatic t_status(input logic [7:0] hi_exp);
    xfer(8'h05, 24'h0, 0, 0, 1, 2, 1'b0, 1'b1, 1'b1, 8'h00, "R12");
    xfer(8'h35, 24'h0, 0, 0, 1, 2, 1'b0, 1'b1, 1'b1, hi_exp, "R12");
  endtask

  task automatic t_quad_refused();
    xfer(8'h6B, 24'h000040, 1, 8, 4, 2, 1'b0, 1'b0, 1'b0, 8'h00, "R7");
    xfer(8'hEB, 24'h000040, 4, 4, 4, 2, 1'b0, 1'b0, 1'b0, 8'h00, "R7");
  endtask

  task automatic t_quad();
    wait_clk(1);
    qe_we = 1'b1;
    qe_d  = 1'b1;
    wait_clk(1);
    qe_we = 1'b0;
    wait_clk(2);
    xfer(8'h6B, 24'h000044, 1, 8, 4, 4, 1'b0, 1'b1, 1'b0, 8'h00, "R6");
    xfer(8'hEB, 24'h3C00C3, 4, 4, 4, 4, 1'b1, 1'b1, 1'b0, 8'h00, "R6");
  endtask

  task automatic t_wrap();
    xfer(8'hEB, 24'h0000FE, 4, 4, 4, 4, 1'b0, 1'b1, 1'b0, 8'h00, "R8");
    xfer(8'h0B, 24'h0000FF, 1, 8, 1, 2, 1'b0, 1'b1, 1'b0, 8'h00, "R8");
  endtask

  task automatic t_abort();
    logic [3:0] s_io, s_oe;
    sclk = 1'b0;
    cs_n = 1'b1;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(4);
    send_header(8'h0B, 24'h000060, 1, 8);
    for (int c = 0; c < 3; c++) spi_cycle(4'b0, s_io, s_oe);
    check("R13", "enable mid byte", 32'(s_oe), 32'h2);
    sclk = 1'b0;
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(8);
    check("R9", "released on abort", 32'(io_oe), 32'd0);
    xfer(8'h0B, 24'h000061, 1, 8, 1, 1, 1'b0, 1'b1, 1'b0, 8'h00, "R9");
  endtask

  task automatic t_bad_opcode();
    xfer(8'h9F, 24'h0, 0, 0, 1, 3, 1'b0, 1'b0, 1'b0, 8'h00, "R2");
    xfer(8'h0B, 24'h000005, 1, 8, 1, 1, 1'b0, 1'b1, 1'b0, 8'h00, "R2");
  endtask

  initial begin
    t_reset_cs_low();
    t_single();
    t_dual();
    t_status(8'h00);
    t_quad_refused();
    t_quad();
    t_status(8'h02);
    t_wrap();
    t_abort();
    t_bad_opcode();
    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

endmodule